// File: doc/BRIEF.md
# Four-Input Packet Stream Multiplexer

This block merges four 32-bit transmit sources into one 32-bit AXI4-Stream output that feeds a MAC. Each source offers words with a valid, a ready, a data word and an end-of-packet flag. A channel-select register names the source that owns the output. The block moves whole packets and never mixes words of two packets on the output.

The select register moves only in the gap between packets. It moves when no packet is in progress and some other source has raised valid. Candidates are scanned in round-robin order, starting from the channel after the current one. The active source's ready follows the downstream ready for the whole packet, so the output can pause in the middle of a packet. The end-of-packet flag of the source becomes the output last flag. The output data, valid and last are registered. A word accepted from a source appears on the output in the next cycle.

From the first cycle a source holds valid high to the first output word, the block takes two cycles when it stays on the same channel and three cycles when it must switch channel first.

Top module: `tx_pkt_mux`

## Requirements
- R1: The channel select changes only while no packet is in progress and some channel other than the selected one has valid high. The scan is round-robin from the channel after the selected one. The selected channel is granted again only when no other channel requests.
- R2: At most one source ready is high at any time, and only the selected channel's ready can be high.
- R3: A word taken from a source (valid and ready both high at a clock edge) appears on the output with output valid high in the next cycle. Data and order are preserved. In the bench, data bits [31:24] carry the channel, [23:16] the packet number and [15:0] the word index.
- R4: The active source's ready follows the downstream ready. It is low whenever the output holds an unaccepted word and downstream ready is low, and it is high during a packet otherwise.
- R5: Output last is high with exactly the word that carried end-of-packet. Once a packet has started on the output, every word up to its last comes from the same source.
- R6: While output valid is high and downstream ready is low, output data and last hold their values. No word is dropped or duplicated.
- R7: When the requesting source is already the selected channel, output valid rises two clock edges after the first edge at which the source's valid is sampled high.
- R8: When the requesting source is not the selected channel, output valid rises three clock edges after the first edge at which the source's valid is sampled high.
- R9: After reset the channel select is 0, no source ready is high and output valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcValid | input | 4 | Per-source word valid, bit n for channel n |
| srcData | input | 128 | Per-source data, channel n in bits [32n+31:32n] |
| srcEop | input | 4 | Per-source end-of-packet flag, valid with the word |
| srcReady | output | 4 | Per-source ready, high only for the active channel |
| mTvalid | output | 1 | Output word valid |
| mTdata | output | 32 | Output word |
| mTlast | output | 1 | Output last word of packet |
| mTready | input | 1 | Downstream ready |

## Verification
The bench measures the two latencies: right after reset on channel 0, after a switch to channel 2, and on a second packet from channel 2. A design with the wrong reset select, or one that skips or adds the grant cycle, shows a latency of 3 instead of 2 or 2 instead of 3. With all four sources requesting, the packet order must follow round-robin. A scan that starts at the wrong channel, or one that re-selects on its own grant, produces a different order. Holding downstream ready low mid-packet must freeze the output word and drop every source ready. A design that loaded anyway would overwrite or drop words, and the per-channel word index check would catch it. The table of mixed lengths, single-word packets, source pauses and ready patterns checks last placement and contiguity. A design that interleaved packets or misplaced last would break the checks on channel, packet number and index.

// File: rtl/tx_pkt_mux_pkg.sv
package tx_pkt_mux_pkg;

  // Arbiter phases: waiting between packets, one-cycle grant after a switch,
  // and forwarding a packet.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GRANT  = 2'd1,
    ST_ACTIVE = 2'd2
  } muxState_t;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic load;   // capture the selected source word into the output register
    logic last;   // the captured word ends its packet
  } dpStrobe_t;

endpackage

// File: rtl/tx_pkt_mux_ctrl.sv
module tx_pkt_mux_ctrl
  import tx_pkt_mux_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] srcValid,
  input  logic [NUM_CH-1:0] srcEop,
  input  logic              outFree,
  output logic [NUM_CH-1:0] srcReady,
  output logic [SEL_W-1:0]  chSel,
  output logic              inPkt,
  output dpStrobe_t         strobe
);

  // NUM_CH is expected to be a power of two (>= 2) so the scan index wraps
  // by truncation.
  muxState_t        state;
  logic             readyAct;
  logic             fire;
  logic             found;
  logic [SEL_W-1:0] nextCh;

  assign readyAct = (state == ST_ACTIVE) && outFree;
  assign fire     = readyAct && srcValid[chSel];
  assign inPkt    = (state == ST_ACTIVE);

  assign strobe.load = fire;
  assign strobe.last = fire && srcEop[chSel];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ready
    assign srcReady[g] = readyAct && (chSel == SEL_W'(g));
  end

  // Round-robin scan over the other channels, nearest after chSel first.
  always_comb begin
    logic [SEL_W-1:0] idx;
    found  = 1'b0;
    nextCh = chSel;
    for (int k = 1; k < NUM_CH; k++) begin
      idx = chSel + SEL_W'(k);
      if (!found && srcValid[idx]) begin
        found  = 1'b1;
        nextCh = idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      chSel <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (found) begin
            chSel <= nextCh;
            state <= ST_GRANT;
          end else if (srcValid[chSel]) begin
            state <= ST_ACTIVE;
          end
        end
        ST_GRANT:  state <= srcValid[chSel] ? ST_ACTIVE : ST_IDLE;
        ST_ACTIVE: if (strobe.last) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tx_pkt_mux_dp.sv
module tx_pkt_mux_dp
  import tx_pkt_mux_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH*DATA_W-1:0] srcData,
  input  logic [SEL_W-1:0]         chSel,
  input  dpStrobe_t                strobe,
  input  logic                     mTready,
  output logic                     mTvalid,
  output logic [DATA_W-1:0]        mTdata,
  output logic                     mTlast,
  output logic                     outFree
);

  logic [DATA_W-1:0] lane [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    assign lane[g] = srcData[g*DATA_W +: DATA_W];
  end

  // The register can take a new word when empty or when its word leaves now.
  assign outFree = !mTvalid || mTready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTvalid <= 1'b0;
      mTdata  <= '0;
      mTlast  <= 1'b0;
    end else if (strobe.load) begin
      mTvalid <= 1'b1;
      mTdata  <= lane[chSel];
      mTlast  <= strobe.last;
    end else if (mTready) begin
      mTvalid <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_pkt_mux.sv
module tx_pkt_mux
  import tx_pkt_mux_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        srcValid,
  input  logic [NUM_CH*DATA_W-1:0] srcData,
  input  logic [NUM_CH-1:0]        srcEop,
  output logic [NUM_CH-1:0]        srcReady,
  output logic                     mTvalid,
  output logic [DATA_W-1:0]        mTdata,
  output logic                     mTlast,
  input  logic                     mTready
);

  dpStrobe_t        strobe;
  logic [SEL_W-1:0] chSel;
  logic             inPkt;
  logic             outFree;

  tx_pkt_mux_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .srcValid (srcValid),
    .srcEop   (srcEop),
    .outFree  (outFree),
    .srcReady (srcReady),
    .chSel    (chSel),
    .inPkt    (inPkt),
    .strobe   (strobe)
  );

  tx_pkt_mux_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcData (srcData),
    .chSel   (chSel),
    .strobe  (strobe),
    .mTready (mTready),
    .mTvalid (mTvalid),
    .mTdata  (mTdata),
    .mTlast  (mTlast),
    .outFree (outFree)
  );

endmodule

// File: rtl/tx_pkt_mux_chk.sv
module tx_pkt_mux_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] srcValid,
  input logic [NUM_CH-1:0] srcEop,
  input logic [NUM_CH-1:0] srcReady,
  input logic [SEL_W-1:0]  chSel,
  input logic              inPkt,
  input logic              mTvalid,
  input logic [DATA_W-1:0] mTdata,
  input logic              mTlast,
  input logic              mTready
);

  AST_SEL_HELD_IN_PKT: assert property (@(posedge clk) disable iff (!rstN)
    inPkt |=> $stable(chSel)); // R1

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcReady)); // R2

  AST_READY_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (srcReady != '0) |-> srcReady[chSel]); // R2

  AST_TAKE_PRESENTS: assert property (@(posedge clk) disable iff (!rstN)
    (|(srcValid & srcReady)) |=> mTvalid); // R3

  AST_STALL_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (mTvalid && !mTready) |-> (srcReady == '0)); // R4

  AST_EOP_MAKES_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (|(srcValid & srcReady & srcEop)) |=> (mTlast && !inPkt)); // R5

  AST_STALL_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (mTvalid && !mTready) |=> (mTvalid && $stable(mTdata) && $stable(mTlast))); // R6

endmodule

bind tx_pkt_mux tx_pkt_mux_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .srcValid (srcValid),
  .srcEop   (srcEop),
  .srcReady (srcReady),
  .chSel    (chSel),
  .inPkt    (inPkt),
  .mTvalid  (mTvalid),
  .mTdata   (mTdata),
  .mTlast   (mTlast),
  .mTready  (mTready)
);

// File: tb/tx_pkt_mux_tb.sv
module tx_pkt_mux_tb;

  localparam int NCH = 4;
  localparam int DW  = 32;

  // Vector: [47:40..23:16] packet length ch0..ch3 (0 = unused), [15:8] ready
  // pattern indexed by cycle mod 8, [7:4] packets per used channel, [0] pause.
  localparam logic [47:0] VEC [6] = '{
    48'h0300_0000_FF20,
    48'h0101_0101_FF10,
    48'h0402_0503_A520,
    48'h0606_0606_3311,
    48'h0207_0001_FE31,
    48'h0800_0800_8121
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [NCH-1:0]    srcValid, srcEop, srcReady;
  logic [NCH*DW-1:0] srcData;
  logic              mTvalid, mTlast, mTready;
  logic [DW-1:0]     mTdata;

  tx_pkt_mux #(.NUM_CH(NCH), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcData(srcData),
    .srcEop(srcEop), .srcReady(srcReady), .mTvalid(mTvalid),
    .mTdata(mTdata), .mTlast(mTlast), .mTready(mTready)
  );

  int total, bad, cyc;
  bit finished;
  int lenC [NCH], pktCnt [NCH], pktDone [NCH], wIdx [NCH], rxPkt [NCH];
  bit gap [NCH];
  bit pauseEn;
  logic [7:0] readyPat;
  bit rxIn;
  int rxCh, rxIdx, rxWords, orderN, firstValidCyc, startCyc;
  int order [16];
  bit seenValid;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void drive();
    for (int i = 0; i < NCH; i++) begin
      bit act;
      act = (pktDone[i] < pktCnt[i]) && !gap[i] && !(pauseEn && ((cyc + i) % 5 == 0));
      srcValid[i] = act;
      srcData[i*DW +: DW] = {8'(i), 8'(pktDone[i]), 16'(wIdx[i])};
      srcEop[i] = act && (wIdx[i] == lenC[i] - 1);
    end
    mTready = readyPat[cyc % 8];
  endfunction

  task automatic monitor(input logic [DW-1:0] d, input logic l);
    if (!rxIn) begin
      if (int'(d[31:24]) >= NCH) begin
        chk(0, "R3 channel field", d[31:24], 0);
        return;
      end
      rxIn = 1; rxCh = int'(d[31:24]); rxIdx = 0;
      if (orderN < 16) begin order[orderN] = rxCh; orderN++; end
    end
    chk(int'(d[31:24]) == rxCh, "R5 no interleave", d[31:24], rxCh);
    chk(int'(d[23:16]) == rxPkt[rxCh], "R3 packet number", d[23:16], rxPkt[rxCh]);
    chk(int'(d[15:0]) == rxIdx, "R6 word index", d[15:0], rxIdx);
    chk(l == (rxIdx == lenC[rxCh] - 1), "R5 last flag", l, (rxIdx == lenC[rxCh] - 1));
    rxIdx++; rxWords++;
    if (l) begin rxPkt[rxCh]++; rxIn = 0; end
  endtask

  task automatic cycleOnce();
    logic [NCH-1:0] fv;
    bit mf;
    logic [DW-1:0] d;
    logic l;
    #1;
    fv = srcValid & srcReady;
    mf = mTvalid && mTready;
    d = mTdata; l = mTlast;
    if (!seenValid && mTvalid) begin seenValid = 1; firstValidCyc = cyc; end
    if ($countones(srcReady) > 1) chk(0, "R2 ready one-hot", srcReady, 0);
    @(posedge clk); @(negedge clk);
    if (mf) monitor(d, l);
    for (int i = 0; i < NCH; i++) begin
      gap[i] = 0;
      if (fv[i]) begin
        if (wIdx[i] == lenC[i] - 1) begin pktDone[i]++; wIdx[i] = 0; gap[i] = 1; end
        else wIdx[i]++;
      end
    end
    cyc++;
    drive();
  endtask

  task automatic startTest();
    for (int i = 0; i < NCH; i++) begin
      pktDone[i] = 0; wIdx[i] = 0; gap[i] = 0; rxPkt[i] = 0;
    end
    rxIn = 0; rxWords = 0; orderN = 0; seenValid = 0;
    startCyc = cyc;
    drive();
  endtask

  task automatic runUntilDone(input int maxC);
    int n;
    n = 0;
    while (n < maxC) begin
      bit all;
      all = 1;
      for (int i = 0; i < NCH; i++) if (pktDone[i] < pktCnt[i]) all = 0;
      if (all && !mTvalid && !rxIn) break;
      cycleOnce();
      n++;
    end
    chk(n < maxC, "R3 test completes", n, maxC);
  endtask

  task automatic onlyChannel(input int ch, input int len);
    for (int i = 0; i < NCH; i++) begin pktCnt[i] = 0; lenC[i] = 1; end
    pktCnt[ch] = 1; lenC[ch] = len;
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0; finished = 0;
    readyPat = 8'hFF; pauseEn = 0;
    for (int i = 0; i < NCH; i++) begin pktCnt[i] = 0; lenC[i] = 1; end
    startTest();
    repeat (4) @(negedge clk);
    #1;
    chk(srcReady == '0, "R9 ready low in reset", srcReady, 0);
    chk(mTvalid == 1'b0, "R9 output valid low in reset", mTvalid, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(srcReady == '0, "R9 ready low after reset", srcReady, 0);
    chk(mTvalid == 1'b0, "R9 output idle after reset", mTvalid, 0);
    @(negedge clk);

    // Channel 0 right after reset: select must be 0, so no switch.
    onlyChannel(0, 3); startTest(); runUntilDone(100);
    chk(firstValidCyc - startCyc == 2, "R7 R9 latency ch0 after reset", firstValidCyc - startCyc, 2);
    chk(rxWords == 3, "R3 words ch0", rxWords, 3);

    // Switch from channel 0 to channel 2.
    onlyChannel(2, 2); startTest(); runUntilDone(100);
    chk(firstValidCyc - startCyc == 3, "R8 latency on switch", firstValidCyc - startCyc, 3);
    chk(rxWords == 2, "R3 words ch2", rxWords, 2);

    // Channel 2 again, no switch.
    onlyChannel(2, 1); startTest(); runUntilDone(100);
    chk(firstValidCyc - startCyc == 2, "R7 latency same channel", firstValidCyc - startCyc, 2);
    chk(rxWords == 1, "R5 single-word packet", rxWords, 1);

    // All four request with select at 2: order 3, 0, 1, 2.
    for (int i = 0; i < NCH; i++) begin pktCnt[i] = 1; lenC[i] = 2; end
    startTest(); runUntilDone(200);
    chk(order[0] == 3, "R1 round-robin first", order[0], 3);
    chk(order[1] == 0, "R1 round-robin second", order[1], 0);
    chk(order[2] == 1, "R1 round-robin third", order[2], 1);
    chk(order[3] == 2, "R1 round-robin fourth", order[3], 2);
    chk(rxWords == 8, "R3 words round-robin", rxWords, 8);

    // Downstream stall with the first word of a channel 1 packet held.
    onlyChannel(1, 3); readyPat = 8'h00; startTest();
    repeat (6) cycleOnce();
    #1;
    chk(mTvalid == 1'b1, "R6 valid held in stall", mTvalid, 1);
    chk(srcReady == '0, "R4 ready low in stall", srcReady, 0);
    chk(mTdata == {8'd1, 8'd0, 16'd0}, "R6 data held in stall", mTdata, {8'd1, 8'd0, 16'd0});
    readyPat = 8'hFF; drive();
    runUntilDone(100);
    chk(rxWords == 3, "R6 no drop or duplicate after stall", rxWords, 3);

    for (int v = 0; v < 6; v++) begin
      int expW;
      expW = 0;
      for (int i = 0; i < NCH; i++) begin
        lenC[i] = int'(VEC[v][47 - 8*i -: 8]);
        pktCnt[i] = (lenC[i] != 0) ? int'(VEC[v][7:4]) : 0;
        if (lenC[i] == 0) lenC[i] = 1;
        expW += (pktCnt[i] != 0) ? lenC[i] * pktCnt[i] : 0;
      end
      readyPat = VEC[v][15:8];
      pauseEn = VEC[v][0];
      startTest();
      runUntilDone(3000);
      chk(rxWords == expW, "R6 vector word count", rxWords, expW);
      for (int i = 0; i < NCH; i++)
        chk(rxPkt[i] == pktCnt[i], "R1 every requester served", rxPkt[i], pktCnt[i]);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R3 run did not finish actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule